// File: doc/BRIEF.md
# Page Permission Check and Reference/Change Update Unit

This block sits after a page table walker has produced a leaf entry. For each request it derives the rights the access may use. The derivation depends on the privilege state of the processor, on whether the check is process-scoped or partition-scoped, and on a user access-rights mask. The block then decides whether the requested access (read, write or execute) faults and, if it faults, builds a cause vector.

When the access is allowed, the block sets the reference bit in the entry. It sets the change bit only for writes. It issues a one-cycle write-back of the updated entry, with the entry's address, only when the entry actually changed. On reads and executes, the write right is removed from the granted set. A later store to the same page therefore has to come back through this unit, which then records the change bit.

All results appear on a registered output stage, one clock after the request.

Top module: `prot_rc_unit`

## Requirements
- R1: An execute access (type code 2) to an entry whose attribute field (bits 5:4) holds 2'b10, meaning non-idempotent I/O, faults. Its cause has the guarded bit (bit 1) set and the protection bit (bit 0) clear, and no permission check is made.
- R2: In a process-scoped check (`part_scope`=0), an entry marked privileged (bit 3) that is accessed in problem state (`user_mode`=1) is granted no rights.
- R3: In problem state, for a privileged entry, or in a partition-scoped check, the granted rights equal the entry's authority bits: read bit 0, write bit 1, execute bit 2.
- R4: A supervisor access to a non-privileged entry in a process-scoped check is granted the entry's authority bits ANDed with `rights_mask` (same bit order).
- R5: Type code 0 needs read, code 1 needs write, code 2 needs execute, and code 3 behaves as a read. A missing needed right gives a fault with cause bit 0 set.
- R6: On an allowed access, the updated entry has the reference bit (bit 6) set. The change bit (bit 7) is set only on a write; otherwise it keeps its original value.
- R7: On an allowed non-write access, the write right (bit 1) is cleared in `rsp_perm`. On an allowed write, `rsp_perm` equals the granted rights.
- R8: `wb_valid` pulses for one cycle, together with `rsp_valid`, only when the access is allowed and the updated entry differs from the original. `wb_addr` and `wb_data` then carry the request's address and the updated entry.
- R9: A fault raised by a write access also sets the store bit (bit 2) of the cause. A faulting access reports `rsp_perm`=0 and issues no write-back.
- R10: Outputs are registered. A request accepted on a clock edge with `req_valid`=1 produces `rsp_valid`=1 after that edge and no other. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_pte | input | PTE_W | Leaf page table entry |
| req_addr | input | ADDR_W | Address of the entry in memory |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| user_mode | input | 1 | Processor in problem state |
| part_scope | input | 1 | 1 = partition-scoped check, 0 = process-scoped |
| rights_mask | input | 3 | User access-rights mask {x,w,r} |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access faults |
| rsp_cause | output | 3 | {store, guarded, protection} |
| rsp_perm | output | 3 | Granted rights {x,w,r} |
| wb_valid | output | 1 | Entry write-back request |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | PTE_W | Updated entry |

## Verification
The embedded assertions check the following on every cycle:
- a write-back never accompanies a fault or an idle cycle, and always carries the reference bit and a value different from the request entry;
- a fault always reports empty rights, and only write faults carry the store bit;
- a granted non-write never holds the write right;
- every execute to an I/O page is reported as guarded.

Which of the four privilege and scope combinations selects which source of rights, and how the mask narrows the supervisor case, is shown only by the bench's directed and random scenarios, compared against its reference model.

// File: rtl/prot_rc_pkg.sv
package prot_rc_pkg;
  localparam logic [1:0] ACC_RD  = 2'd0;
  localparam logic [1:0] ACC_WR  = 2'd1;
  localparam logic [1:0] ACC_EX  = 2'd2;
  localparam logic [1:0] ACC_RD2 = 2'd3;

  localparam int AUTH_LO  = 0;
  localparam int PRIV_BIT = 3;
  localparam int ATTR_LO  = 4;
  localparam int REF_BIT  = 6;
  localparam int CHG_BIT  = 7;

  localparam logic [1:0] ATTR_NIO = 2'b10;

  localparam int CS_PROT  = 0;
  localparam int CS_GUARD = 1;
  localparam int CS_STORE = 2;

  localparam int RT_R = 0;
  localparam int RT_W = 1;
  localparam int RT_X = 2;
endpackage

// File: rtl/prot_perm_eval.sv
module prot_perm_eval
  import prot_rc_pkg::*;
(
  input  logic [2:0] auth,
  input  logic       priv_pg,
  input  logic [1:0] attr,
  input  logic [1:0] acc,
  input  logic       user_mode,
  input  logic       part_scope,
  input  logic [2:0] rights_mask,
  output logic       fault,
  output logic [2:0] cause,
  output logic [2:0] perm
);
  logic [2:0] granted;
  logic [2:0] needed;
  logic       guard_hit;

  always_comb begin
    if (!part_scope && priv_pg && user_mode)
      granted = 3'b000;
    else if (user_mode || priv_pg || part_scope)
      granted = auth;
    else
      granted = auth & rights_mask;
  end

  always_comb begin
    needed = '0;
    unique case (acc)
      ACC_WR:  needed[RT_W] = 1'b1;
      ACC_EX:  needed[RT_X] = 1'b1;
      default: needed[RT_R] = 1'b1;
    endcase
  end

  assign guard_hit = (acc == ACC_EX) && (attr == ATTR_NIO);

  always_comb begin
    cause = '0;
    fault = 1'b0;
    perm  = '0;
    if (guard_hit) begin
      fault           = 1'b1;
      cause[CS_GUARD] = 1'b1;
    end else if ((needed & ~granted) != 3'b000) begin
      fault          = 1'b1;
      cause[CS_PROT] = 1'b1;
    end else begin
      perm = granted;
      if (acc != ACC_WR) perm[RT_W] = 1'b0;
    end
    if (fault && acc == ACC_WR) cause[CS_STORE] = 1'b1;
  end
endmodule

// File: rtl/prot_rc_merge.sv
module prot_rc_merge
  import prot_rc_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_in,
  input  logic             is_write,
  input  logic             allow,
  output logic [PTE_W-1:0] pte_out,
  output logic             changed
);
  always_comb begin
    pte_out          = pte_in;
    pte_out[REF_BIT] = 1'b1;
    if (is_write) pte_out[CHG_BIT] = 1'b1;
  end

  assign changed = allow && (pte_out != pte_in);
endmodule

// File: rtl/prot_rc_unit.sv
module prot_rc_unit
  import prot_rc_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PTE_W-1:0]  req_pte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_acc,
  input  logic              user_mode,
  input  logic              part_scope,
  input  logic [2:0]        rights_mask,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [2:0]        rsp_perm,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTE_W-1:0]  wb_data
);
  logic             c_fault;
  logic [2:0]       c_cause;
  logic [2:0]       c_perm;
  logic [PTE_W-1:0] c_pte;
  logic             c_changed;

  prot_perm_eval u_eval (
    .auth        (req_pte[AUTH_LO +: 3]),
    .priv_pg     (req_pte[PRIV_BIT]),
    .attr        (req_pte[ATTR_LO +: 2]),
    .acc         (req_acc),
    .user_mode   (user_mode),
    .part_scope  (part_scope),
    .rights_mask (rights_mask),
    .fault       (c_fault),
    .cause       (c_cause),
    .perm        (c_perm)
  );

  prot_rc_merge #(.PTE_W(PTE_W)) u_merge (
    .pte_in   (req_pte),
    .is_write (req_acc == ACC_WR),
    .allow    (!c_fault),
    .pte_out  (c_pte),
    .changed  (c_changed)
  );

  logic              rv_d, flt_d, wbv_d;
  logic [2:0]        cs_d, pm_d;
  logic              dat_en;

  always_comb begin
    rv_d   = req_valid;
    flt_d  = req_valid && c_fault;
    cs_d   = req_valid ? c_cause : 3'b000;
    pm_d   = req_valid ? c_perm  : 3'b000;
    wbv_d  = req_valid && c_changed;
    dat_en = req_valid && c_changed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_perm  <= '0;
      wb_valid  <= 1'b0;
    end else begin
      rsp_valid <= rv_d;
      rsp_fault <= flt_d;
      rsp_cause <= cs_d;
      rsp_perm  <= pm_d;
      wb_valid  <= wbv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_addr <= '0;
      wb_data <= '0;
    end else if (dat_en) begin
      wb_addr <= req_addr;
      wb_data <= c_pte;
    end
  end

  assert_wb_allowed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && !rsp_fault));

  assert_wb_differs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> (wb_data != $past(req_pte)));

  assert_wb_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[REF_BIT]);

  assert_fault_noperm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_perm == 3'b000 && !wb_valid));

  assert_store_only_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause[CS_STORE] |-> (rsp_fault && $past(req_acc) == ACC_WR));

  assert_nonwrite_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_acc) != ACC_WR) |-> !rsp_perm[RT_W]);

  assert_guard_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $past(req_acc) == ACC_EX &&
     $past(req_pte[ATTR_LO +: 2]) == ATTR_NIO) |-> (rsp_fault && rsp_cause[CS_GUARD]));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
endmodule

// File: tb/sim_prot_rc_unit.sv
module sim_prot_rc_unit;
  localparam int CLK_PER = 10;
  localparam int PW = 64;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [PW-1:0] req_pte;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_acc;
  logic          user_mode, part_scope;
  logic [2:0]    rights_mask;
  logic          rsp_valid, rsp_fault, wb_valid;
  logic [2:0]    rsp_cause, rsp_perm;
  logic [AW-1:0] wb_addr;
  logic [PW-1:0] wb_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  prot_rc_unit #(.PTE_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
    .req_addr(req_addr), .req_acc(req_acc), .user_mode(user_mode),
    .part_scope(part_scope), .rights_mask(rights_mask),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_perm(rsp_perm), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model: behavioural, from the requirements
  task automatic send(input string tag, input logic [63:0] pte, input int acc,
                      input bit usr, input bit part, input int msk, input logic [47:0] addr);
    int auth, g, need, e_perm, e_cause;
    bit e_fault, e_wb;
    logic [63:0] npte;
    req_valid = 1; req_pte = pte; req_acc = acc[1:0]; user_mode = usr;
    part_scope = part; rights_mask = msk[2:0]; req_addr = addr;
    auth = int'(pte[2:0]);
    e_perm = 0; e_cause = 0; e_fault = 0; e_wb = 0; npte = pte;
    if (acc == 2 && pte[5:4] == 2'b10) begin
      e_fault = 1; e_cause = 2;
    end else begin
      if (!part && pte[3] && usr) g = 0;
      else if (usr || pte[3] || part) g = auth;
      else g = auth & msk;
      need = (acc == 1) ? 2 : (acc == 2) ? 4 : 1;
      if ((need & ~g) != 0) begin
        e_fault = 1; e_cause = 1;
      end else begin
        e_perm = (acc == 1) ? g : (g & 5);
        npte = pte | 64'h40 | ((acc == 1) ? 64'h80 : 64'h0);
        e_wb = (npte != pte);
      end
    end
    if (e_fault && acc == 1) e_cause = e_cause + 4;
    @(posedge clk); #(CLK_PER/4);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    chk({tag, " cause"}, 64'(rsp_cause), 64'(e_cause));
    chk({tag, " perm"}, 64'(rsp_perm), 64'(e_perm));
    chk({tag, " wb"}, 64'(wb_valid), 64'(e_wb));
    if (e_wb) begin
      chk({tag, " wbaddr"}, 64'(wb_addr), 64'(addr));
      chk({tag, " wbdata"}, wb_data, npte);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input string tag);
    req_valid = 0;
    @(posedge clk); #(CLK_PER/4);
    chk({tag, " idle valid"}, 64'(rsp_valid), 64'd0);
    chk({tag, " idle wb"}, 64'(wb_valid), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_pte = '0; req_addr = '0; req_acc = 0;
    user_mode = 0; part_scope = 0; rights_mask = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 64'(rsp_valid), 0);
    chk("R10 reset wb", 64'(wb_valid), 0);
    chk("R10 reset perm", 64'(rsp_perm), 0);
    rst_n = 1;
    @(negedge clk);
    idle("R10");
    // R1 guarded exec on I/O page, even with all rights
    send("R1 guard", 64'h27, 2, 0, 1, 7, 48'h1000);
    send("R1 io read ok", 64'h27, 0, 0, 1, 7, 48'h1008);
    // R2 privileged page in user mode, process-scoped
    send("R2 priv user rd", 64'h0F, 0, 1, 0, 7, 48'h2000);
    send("R2 priv user wr", 64'h0F, 1, 1, 0, 7, 48'h2008);
    // R3 partition scope privileged user ok
    send("R3 part priv user", 64'h0F, 1, 1, 1, 0, 48'h3000);
    send("R3 user nonpriv", 64'h05, 2, 1, 0, 0, 48'h3008);
    send("R3 sup priv ignores mask", 64'h0B, 1, 0, 0, 0, 48'h3010);
    // R4 supervisor non-priv process-scoped uses mask
    send("R4 mask blocks write", 64'h07, 1, 0, 0, 5, 48'h4000);
    send("R4 mask allows read", 64'h07, 0, 0, 0, 1, 48'h4008);
    send("R4 mask blocks exec", 64'h07, 2, 0, 0, 3, 48'h4010);
    // R5 access codes
    send("R5 code3 read", 64'h01, 3, 1, 0, 0, 48'h5000);
    send("R5 no read", 64'h06, 0, 1, 0, 0, 48'h5008);
    // R6/R8 ref already set: no write-back on read
    send("R8 no change rd", 64'h47, 0, 1, 0, 0, 48'h6000);
    send("R6 change on write", 64'h47, 1, 1, 0, 0, 48'h6008);
    send("R8 both set write", 64'hC7, 1, 1, 0, 0, 48'h6010);
    send("R6 chg kept rd", 64'h83, 0, 1, 0, 0, 48'h6018);
    // R7 read strips write
    send("R7 strip w", 64'h07, 0, 1, 0, 0, 48'h7000);
    // R9 store bit on write fault, none on exec fault
    send("R9 wr fault", 64'h01, 1, 1, 0, 0, 48'h9000);
    send("R9 ex fault", 64'h01, 2, 1, 0, 0, 48'h9008);
    idle("R10");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      send("R4 random", p, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 48'({$urandom, $urandom}));
      if (i % 7 == 0) idle("R10");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule